// File: doc/BRIEF.md
# Pipelined Nonvolatile Command Sequencer

This block is the command front end of an emulated-EEPROM array. Software starts an operation with three writes in a fixed order: an aligned word write into the array window, which captures address and data; a write of the command code; and a write of 1 to the buffer-empty bit of the status register, which launches it. A launched command sits in a one-entry pending slot until the array engine is free. The buffer-empty bit then sets again, so a second command can be assembled while the first one runs.

The block owns the status flags and the two interrupt requests, and it rejects any out-of-order access with a sticky access-error flag. The array engine is modelled internally as a countdown of divider ticks, with a fixed length for each operation type. A blank-check input is sampled when an erase verify finishes. The array itself, its charge pumps and its real cell timing lie outside the block.

Top module: `nv_cmd_seq`

## Requirements
- R1: A word write (arrByte=0, arrAddr[0]=0, divReady=1, buffer empty) followed by a valid command write (regSel=2) and a status write (regSel=1) with bit 0 set launches the command. The engine runs it for its fixed tick count: erase verify 2, word program 3, sector erase 4, mass erase 5 (defaults, one tick per cycle).
- R2: Command codes 0x05 erase verify, 0x20 word program, 0x40 sector erase, 0x41 mass erase and 0x60 sector modify are accepted. Any other code written after the word write sets access error (status bit 2), and nothing is launched.
- R3: A launch clears buffer-empty (status bit 0) and done (status bit 1). Buffer-empty sets again as soon as the engine takes the command, so a second command can be queued while the first one runs.
- R4: Done sets only when the engine has finished and no command is pending. A launch in the same cycle as a finish keeps done clear, and the queued command then runs to completion.
- R5: Each of the following aborts the sequence and sets access error: an array write with divReady=0; a byte write; a write with arrAddr[0]=1; an array write while buffer-empty is clear; a second word write; a configuration write (regSel=0) after the word write; a second command write; a configuration write after the command write; a status write with bit 0 clear after the command write.
- R6: Access error (status bit 2) and protection violation (status bit 3) clear only when 1 is written to their bit in a status write; writing 0 leaves them set. While either is set, array writes are ignored and no command launches.
- R7: Blank (status bit 4) takes the blankIn value when an erase verify finishes. It clears when the next command is launched.
- R8: A stopReq pulse while a command is active ends it, discards any pending command, and sets done, access error and buffer-empty.
- R9: After reset, statusOut is 0x03 (buffer-empty and done set, all else 0). irqBufEmpty equals buffer-empty ANDed with configuration bit 0, and irqDone equals done ANDed with configuration bit 1.
- R10: Sector modify runs a sector erase and then a word program as one command, which makes 7 ticks by default. For sector erase and sector modify, engAddr has its two low bits forced to 0.
- R11: With protAll=1, launching any command other than erase verify sets protection violation and starts nothing. Erase verify still runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| divReady | input | 1 | Timing divider has been loaded |
| divTick | input | 1 | One pulse per divided engine time unit |
| arrWrEn | input | 1 | Write strobe into the array window |
| arrByte | input | 1 | Array write is a single byte |
| arrAddr | input | AW | Array byte address |
| arrData | input | DW | Array write data |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 configuration, 1 status, 2 command |
| regWrData | input | 8 | Register write data |
| protAll | input | 1 | Whole array protected against program and erase |
| stopReq | input | 1 | Stop request pulse |
| blankIn | input | 1 | Blank-check result from the array |
| statusOut | output | 8 | Status: bit0 buffer-empty, bit1 done, bit2 access error, bit3 protection violation, bit4 blank |
| irqBufEmpty | output | 1 | Buffer-empty interrupt request |
| irqDone | output | 1 | Completion interrupt request |
| engBusy | output | 1 | Engine is running a command |
| engOp | output | 2 | Current engine operation: 0 verify, 1 program, 2 sector erase, 3 mass erase |
| engAddr | output | AW | Address given to the engine |
| engData | output | DW | Data given to the engine |

## Verification
The sharpest collision is a launch that lands in the same cycle in which the engine finishes its previous command. The pending slot was empty until that moment, so a careless design would raise done there. The bench launches a word program, immediately assembles a second sequence, and times the launch write to meet the last tick of the first command. It then requires done to stay low at that edge and to rise only after the queued command's own four cycles. A second case drives a stop pulse while one command runs and another waits, and requires that the waiting one never starts.

// File: rtl/nv_seq_pkg.sv
package nv_seq_pkg;

  typedef enum logic [1:0] {
    OP_VERIFY = 2'd0,
    OP_PROG   = 2'd1,
    OP_SECT   = 2'd2,
    OP_MASS   = 2'd3
  } nvOpE;

  // control-to-datapath strobes
  typedef struct packed {
    logic latchWord;
    logic latchCmd;
    logic launch;
    logic flush;
  } seqStrobeT;

  localparam logic [7:0] CODE_VERIFY = 8'h05;
  localparam logic [7:0] CODE_PROG   = 8'h20;
  localparam logic [7:0] CODE_SECT   = 8'h40;
  localparam logic [7:0] CODE_MASS   = 8'h41;
  localparam logic [7:0] CODE_MODIFY = 8'h60;

  function automatic logic codeValid(input logic [7:0] c);
    case (c)
      CODE_VERIFY, CODE_PROG, CODE_SECT, CODE_MASS, CODE_MODIFY: codeValid = 1'b1;
      default: codeValid = 1'b0;
    endcase
  endfunction

  function automatic nvOpE codeOp(input logic [7:0] c);
    case (c)
      CODE_VERIFY: codeOp = OP_VERIFY;
      CODE_SECT:   codeOp = OP_SECT;
      CODE_MASS:   codeOp = OP_MASS;
      CODE_MODIFY: codeOp = OP_SECT;
      default:     codeOp = OP_PROG;
    endcase
  endfunction

endpackage

// File: rtl/nv_seq_engine.sv
module nv_seq_engine
  import nv_seq_pkg::*;
#(
  parameter int T_VERIFY = 2,
  parameter int T_PROG   = 3,
  parameter int T_SECT   = 4,
  parameter int T_MASS   = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic take,
  input  nvOpE takeOp,
  input  logic takeMod,
  input  logic divTick,
  input  logic flush,
  output logic busy,
  output logic finish,
  output nvOpE curOp
);

  localparam int TMAX01 = (T_VERIFY > T_PROG) ? T_VERIFY : T_PROG;
  localparam int TMAX23 = (T_SECT > T_MASS) ? T_SECT : T_MASS;
  localparam int TMAX   = (TMAX01 > TMAX23) ? TMAX01 : TMAX23;
  localparam int CW     = $clog2(TMAX + 1);

  logic [CW-1:0] cnt;
  logic          second;

  function automatic logic [CW-1:0] durOf(input nvOpE op);
    case (op)
      OP_VERIFY: durOf = CW'(T_VERIFY);
      OP_PROG:   durOf = CW'(T_PROG);
      OP_SECT:   durOf = CW'(T_SECT);
      default:   durOf = CW'(T_MASS);
    endcase
  endfunction

  wire lastTick = busy && divTick && (cnt == CW'(1));
  assign finish = lastTick && !second && !flush;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      second <= 1'b0;
      cnt    <= '0;
      curOp  <= OP_VERIFY;
    end else if (flush) begin
      busy   <= 1'b0;
      second <= 1'b0;
    end else if (take) begin
      busy   <= 1'b1;
      curOp  <= takeOp;
      second <= takeMod;
      cnt    <= durOf(takeOp);
    end else if (busy && divTick) begin
      if (cnt == CW'(1)) begin
        if (second) begin
          curOp  <= OP_PROG;
          cnt    <= CW'(T_PROG);
          second <= 1'b0;
        end else begin
          busy <= 1'b0;
        end
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  // a finishing command leaves the engine idle at the next edge
  AST_FINISH_IDLES: assert property (@(posedge clk) disable iff (!rstN)
    finish |=> !busy); // R1

endmodule

// File: rtl/nv_seq_dp.sv
module nv_seq_dp
  import nv_seq_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobeT     strobes,
  input  logic [AW-1:0] arrAddr,
  input  logic [DW-1:0] arrData,
  input  logic [7:0]    cmdCode,
  input  logic          engBusy,
  output logic          pendValid,
  output logic          take,
  output logic          seqIsVerify,
  output nvOpE          takeOp,
  output logic          takeMod,
  output logic [AW-1:0] engAddr,
  output logic [DW-1:0] engData
);

  logic [AW-1:0] seqAddr, pendAddr;
  logic [DW-1:0] seqData, pendData;
  nvOpE          seqOp, pendOp;
  logic          seqMod, pendMod;

  assign seqIsVerify = (seqOp == OP_VERIFY) && !seqMod;
  assign take        = pendValid && !engBusy && !strobes.flush;
  assign takeOp      = pendOp;
  assign takeMod     = pendMod;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqAddr   <= '0;
      seqData   <= '0;
      seqOp     <= OP_VERIFY;
      seqMod    <= 1'b0;
      pendAddr  <= '0;
      pendData  <= '0;
      pendOp    <= OP_VERIFY;
      pendMod   <= 1'b0;
      pendValid <= 1'b0;
      engAddr   <= '0;
      engData   <= '0;
    end else begin
      if (strobes.latchWord) begin
        seqAddr <= arrAddr;
        seqData <= arrData;
      end
      if (strobes.latchCmd) begin
        seqOp  <= codeOp(cmdCode);
        seqMod <= (cmdCode == CODE_MODIFY);
      end
      if (strobes.flush) begin
        pendValid <= 1'b0;
      end else if (strobes.launch) begin
        pendValid <= 1'b1;
        pendAddr  <= seqAddr;
        pendData  <= seqData;
        pendOp    <= seqOp;
        pendMod   <= seqMod;
      end else if (take) begin
        pendValid <= 1'b0;
      end
      if (take) begin
        engAddr <= (pendOp == OP_SECT) ? {pendAddr[AW-1:2], 2'b00} : pendAddr;
        engData <= pendData;
      end
    end
  end

  // a launch never lands on an occupied pending slot
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.launch |-> !pendValid); // R3

endmodule

// File: rtl/nv_seq_ctrl.sv
module nv_seq_ctrl
  import nv_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       divReady,
  input  logic       arrWrEn,
  input  logic       arrByte,
  input  logic       arrAddrLsb,
  input  logic       regWrEn,
  input  logic [1:0] regSel,
  input  logic [7:0] regWrData,
  input  logic       protAll,
  input  logic       stopReq,
  input  logic       blankIn,
  input  logic       seqIsVerify,
  input  logic       pendValid,
  input  logic       take,
  input  logic       busy,
  input  logic       finish,
  input  nvOpE       curOp,
  output seqStrobeT  strobes,
  output logic [7:0] statusOut,
  output logic       irqBufEmpty,
  output logic       irqDone
);

  typedef enum logic [1:0] {S_IDLE, S_WORD, S_CMD} seqStE;

  seqStE seqSt, nextSt;
  logic  bufEmpty, done, accErr, protViol, blank, ieBuf, ieDone;
  logic  setAcc, setProt;

  wire errLock = accErr || protViol;
  wire wrCfg   = regWrEn && (regSel == 2'd0);
  wire wrStat  = regWrEn && (regSel == 2'd1);
  wire wrCmd   = regWrEn && (regSel == 2'd2);

  always_comb begin
    strobes = '0;
    setAcc  = 1'b0;
    setProt = 1'b0;
    nextSt  = seqSt;
    if (stopReq && (busy || pendValid)) begin
      strobes.flush = 1'b1;
      nextSt        = S_IDLE;
    end else if (arrWrEn) begin
      if (!errLock) begin
        if (!divReady || arrByte || arrAddrLsb || !bufEmpty || seqSt != S_IDLE) begin
          setAcc = 1'b1;
          nextSt = S_IDLE;
        end else begin
          strobes.latchWord = 1'b1;
          nextSt            = S_WORD;
        end
      end
    end else if (wrCmd) begin
      if (seqSt == S_WORD && codeValid(regWrData)) begin
        strobes.latchCmd = 1'b1;
        nextSt           = S_CMD;
      end else begin
        setAcc = 1'b1;
        nextSt = S_IDLE;
      end
    end else if (wrCfg) begin
      if (seqSt != S_IDLE) begin
        setAcc = 1'b1;
        nextSt = S_IDLE;
      end
    end else if (wrStat) begin
      if (seqSt == S_WORD) begin
        setAcc = 1'b1;
        nextSt = S_IDLE;
      end else if (seqSt == S_CMD) begin
        nextSt = S_IDLE;
        if (!regWrData[0])                setAcc = 1'b1;
        else if (protAll && !seqIsVerify) setProt = 1'b1;
        else if (!errLock)                strobes.launch = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqSt    <= S_IDLE;
      bufEmpty <= 1'b1;
      done     <= 1'b1;
      accErr   <= 1'b0;
      protViol <= 1'b0;
      blank    <= 1'b0;
      ieBuf    <= 1'b0;
      ieDone   <= 1'b0;
    end else begin
      seqSt <= nextSt;
      if (wrCfg) begin
        ieBuf  <= regWrData[0];
        ieDone <= regWrData[1];
      end
      if (setAcc || strobes.flush)         accErr <= 1'b1;
      else if (wrStat && regWrData[2])     accErr <= 1'b0;
      if (setProt)                         protViol <= 1'b1;
      else if (wrStat && regWrData[3])     protViol <= 1'b0;
      if (strobes.flush) begin
        bufEmpty <= 1'b1;
        done     <= 1'b1;
      end else if (strobes.launch) begin
        bufEmpty <= 1'b0;
        done     <= 1'b0;
        blank    <= 1'b0;
      end else begin
        if (take)                           bufEmpty <= 1'b1;
        if (finish && !pendValid)           done <= 1'b1;
        if (finish && curOp == OP_VERIFY)   blank <= blankIn;
      end
    end
  end

  assign statusOut   = {3'b000, blank, protViol, accErr, done, bufEmpty};
  assign irqBufEmpty = bufEmpty && ieBuf;
  assign irqDone     = done && ieDone;

  AST_LAUNCH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.launch |=> (!bufEmpty && !done)); // R3
  AST_DONE_ALL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (!busy && !pendValid)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (accErr && !(wrStat && regWrData[2])) |=> accErr); // R6
  AST_BLANK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.launch |=> !blank); // R7
  AST_STOP_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && busy) |=> (done && accErr && bufEmpty && !busy)); // R8

endmodule

// File: rtl/nv_cmd_seq.sv
module nv_cmd_seq
  import nv_seq_pkg::*;
#(
  parameter int AW       = 12,
  parameter int DW       = 16,
  parameter int T_VERIFY = 2,
  parameter int T_PROG   = 3,
  parameter int T_SECT   = 4,
  parameter int T_MASS   = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          divReady,
  input  logic          divTick,
  input  logic          arrWrEn,
  input  logic          arrByte,
  input  logic [AW-1:0] arrAddr,
  input  logic [DW-1:0] arrData,
  input  logic          regWrEn,
  input  logic [1:0]    regSel,
  input  logic [7:0]    regWrData,
  input  logic          protAll,
  input  logic          stopReq,
  input  logic          blankIn,
  output logic [7:0]    statusOut,
  output logic          irqBufEmpty,
  output logic          irqDone,
  output logic          engBusy,
  output logic [1:0]    engOp,
  output logic [AW-1:0] engAddr,
  output logic [DW-1:0] engData
);

  seqStrobeT strobes;
  logic      pendValid, take, seqIsVerify, takeMod, finish;
  nvOpE      takeOp, curOp;

  nv_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .divReady(divReady), .arrWrEn(arrWrEn),
    .arrByte(arrByte), .arrAddrLsb(arrAddr[0]), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .protAll(protAll),
    .stopReq(stopReq), .blankIn(blankIn), .seqIsVerify(seqIsVerify),
    .pendValid(pendValid), .take(take), .busy(engBusy), .finish(finish),
    .curOp(curOp), .strobes(strobes), .statusOut(statusOut),
    .irqBufEmpty(irqBufEmpty), .irqDone(irqDone)
  );

  nv_seq_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .arrAddr(arrAddr),
    .arrData(arrData), .cmdCode(regWrData), .engBusy(engBusy),
    .pendValid(pendValid), .take(take), .seqIsVerify(seqIsVerify),
    .takeOp(takeOp), .takeMod(takeMod), .engAddr(engAddr), .engData(engData)
  );

  nv_seq_engine #(.T_VERIFY(T_VERIFY), .T_PROG(T_PROG), .T_SECT(T_SECT), .T_MASS(T_MASS)) u_eng (
    .clk(clk), .rstN(rstN), .take(take), .takeOp(takeOp), .takeMod(takeMod),
    .divTick(divTick), .flush(strobes.flush), .busy(engBusy),
    .finish(finish), .curOp(curOp)
  );

  assign engOp = curOp;

endmodule

// File: tb/nv_cmd_seq_bench.sv
module nv_cmd_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        divReady = 1'b1, divTick = 1'b1;
  logic        arrWrEn = 1'b0, arrByte = 1'b0;
  logic [11:0] arrAddr = '0;
  logic [15:0] arrData = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = '0;
  logic [7:0]  regWrData = '0;
  logic        protAll = 1'b0, stopReq = 1'b0, blankIn = 1'b0;
  logic [7:0]  statusOut;
  logic        irqBufEmpty, irqDone, engBusy;
  logic [1:0]  engOp;
  logic [11:0] engAddr;
  logic [15:0] engData;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  nv_cmd_seq u_nv_cmd_seq (
    .clk(clk), .rstN(rstN), .divReady(divReady), .divTick(divTick),
    .arrWrEn(arrWrEn), .arrByte(arrByte), .arrAddr(arrAddr), .arrData(arrData),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .protAll(protAll), .stopReq(stopReq), .blankIn(blankIn),
    .statusOut(statusOut), .irqBufEmpty(irqBufEmpty), .irqDone(irqDone),
    .engBusy(engBusy), .engOp(engOp), .engAddr(engAddr), .engData(engData)
  );

  // code, expected cycles from first busy cycle to done (0 = rejected)
  localparam logic [7:0] VEC_CODE [0:7] = '{8'h05, 8'h20, 8'h40, 8'h41, 8'h60, 8'h00, 8'h21, 8'hFF};
  localparam int         VEC_LEN  [0:7] = '{2, 3, 4, 5, 7, 0, 0, 0};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic arrWr(input logic [11:0] a, input logic byteOnly);
    arrWrEn = 1'b1; arrAddr = a; arrByte = byteOnly; arrData = 16'hA5C3 ^ {4'h0, a};
    step();
    arrWrEn = 1'b0; arrByte = 1'b0;
  endtask

  task automatic regWr(input logic [1:0] sel, input logic [7:0] d);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic issue(input logic [7:0] code, input logic [11:0] a);
    arrWr(a, 1'b0);
    regWr(2'd2, code);
    regWr(2'd1, 8'h01);
  endtask

  task automatic waitDone(output int n);
    n = 0;
    while (!statusOut[1] && n < 1000) begin
      step();
      n++;
    end
  endtask

  task automatic clearErr();
    regWr(2'd1, 8'h0C);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nErrors++; nChecks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9 reset state and interrupt gating
    check("R9 reset status", statusOut, 8'h03);
    check("R9 irqs off", {irqBufEmpty, irqDone}, 2'b00);
    check("R9 engine idle", engBusy, 1'b0);
    regWr(2'd0, 8'h03);
    check("R9 irqs on", {irqBufEmpty, irqDone}, 2'b11);

    // R1 R2 R10 table of command codes
    for (int i = 0; i < 8; i++) begin
      clearErr();
      if (VEC_LEN[i] == 0) begin
        arrWr(12'h106, 1'b0);
        regWr(2'd2, VEC_CODE[i]);
        check("R2 bad code sets error", statusOut[2], 1'b1);
        regWr(2'd1, 8'h01);
        check("R2 bad code not launched", engBusy, 1'b0);
      end else begin
        issue(VEC_CODE[i], 12'h106);
        if (i == 1) check("R9 irqs drop on launch", {irqBufEmpty, irqDone}, 2'b00);
        step();
        check("R1 engine busy", engBusy, 1'b1);
        check("R10 engine address", engAddr,
              (VEC_CODE[i] == 8'h40 || VEC_CODE[i] == 8'h60) ? 12'h104 : 12'h106);
        waitDone(n);
        check("R1 R10 command duration", n, VEC_LEN[i]);
        check("R2 valid code no error", statusOut[2], 1'b0);
      end
    end
    clearErr();

    // R3 R4 queue a second command; launch meets the finish of the first
    issue(8'h20, 12'h010);
    check("R3 launch clears buffer-empty and done", statusOut[1:0], 2'b00);
    step();
    check("R3 buffer-empty sets when engine takes", statusOut[0], 1'b1);
    issue(8'h20, 12'h020);
    check("R4 done held on coincident launch", statusOut[1], 1'b0);
    waitDone(n);
    check("R4 done after queued command", n, 4);

    // R5 sequence violations
    divReady = 1'b0; arrWr(12'h030, 1'b0); divReady = 1'b1;
    check("R5 divider not ready", statusOut[2], 1'b1); clearErr();
    arrWr(12'h030, 1'b1);
    check("R5 byte write", statusOut[2], 1'b1); clearErr();
    arrWr(12'h031, 1'b0);
    check("R5 misaligned", statusOut[2], 1'b1); clearErr();
    arrWr(12'h030, 1'b0); arrWr(12'h032, 1'b0);
    check("R5 second word", statusOut[2], 1'b1); clearErr();
    arrWr(12'h030, 1'b0); regWr(2'd0, 8'h03);
    check("R5 config after word", statusOut[2], 1'b1); clearErr();
    arrWr(12'h030, 1'b0); regWr(2'd2, 8'h20); regWr(2'd2, 8'h20);
    check("R5 second command", statusOut[2], 1'b1); clearErr();
    arrWr(12'h030, 1'b0); regWr(2'd2, 8'h20); regWr(2'd0, 8'h03);
    check("R5 config after command", statusOut[2], 1'b1); clearErr();
    arrWr(12'h030, 1'b0); regWr(2'd2, 8'h20); regWr(2'd1, 8'h00);
    check("R5 zero to buffer-empty", statusOut[2], 1'b1);
    check("R5 aborted not launched", engBusy, 1'b0); clearErr();
    issue(8'h41, 12'h040); arrWr(12'h050, 1'b0);
    check("R5 word while buffer full", statusOut[2], 1'b1);
    waitDone(n); clearErr();

    // R8 stop while active
    issue(8'h41, 12'h060); step();
    stopReq = 1'b1; step(); stopReq = 1'b0;
    check("R8 stop flags", statusOut[2:0], 3'b111);
    check("R8 stop idles engine", engBusy, 1'b0);
    // R6 lock while error set
    issue(8'h20, 12'h070); step();
    check("R6 no launch while locked", engBusy, 1'b0);
    regWr(2'd1, 8'h00);
    check("R6 zero write keeps error", statusOut[2], 1'b1);
    regWr(2'd1, 8'h04);
    check("R6 one write clears error", statusOut[2], 1'b0);
    // R8 pending discarded
    issue(8'h41, 12'h080); step();
    issue(8'h20, 12'h090);
    stopReq = 1'b1; step(); stopReq = 1'b0;
    repeat (8) step();
    check("R8 pending discarded", {engBusy, statusOut[1]}, 2'b01);
    clearErr();

    // R11 protection
    protAll = 1'b1;
    issue(8'h20, 12'h0A0); step();
    check("R11 protected program flagged", {statusOut[3], engBusy}, 2'b10);
    regWr(2'd1, 8'h00);
    check("R11 R6 zero write keeps violation", statusOut[3], 1'b1);
    regWr(2'd1, 8'h08);
    issue(8'h05, 12'h0A0);
    waitDone(n);
    check("R11 verify runs while protected", {statusOut[3], n[7:0]}, {1'b0, 8'd3});
    protAll = 1'b0;

    // R7 blank result
    blankIn = 1'b1;
    issue(8'h05, 12'h0B0); waitDone(n);
    check("R7 blank set", statusOut[4], 1'b1);
    blankIn = 1'b0;
    arrWr(12'h0B0, 1'b0); regWr(2'd2, 8'h20);
    check("R7 blank kept before launch", statusOut[4], 1'b1);
    regWr(2'd1, 8'h01);
    check("R7 blank cleared by launch", statusOut[4], 1'b0);
    waitDone(n);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule